// File: doc/BRIEF.md
# Gated Parent-Select Clock Divider

This block produces a module clock from one of several parent clocks. A single 32-bit control word chooses the parent, sets a power-of-two pre-divide and a linear divide from 1 to 16, and gates the output. The overall ratio is `(M+1) << P` parent cycles per output cycle, so the output is never faster than the chosen parent.

Everything runs on one fast system clock. Each parent clock is a one-cycle tick input that marks one parent cycle. The block drives two outputs. `mod_ce` is a clock-enable strobe, one pulse per output period. `mod_clk` is a level with the output's duty cycle. Downstream logic can use the strobe as a clock enable, and the level stands in for the divided clock.

A new setting written while the output is running is held back until the current output period ends. This prevents runt or stretched pulses.

Top module: `clkdiv_gated_mux`

## Requirements
- R1: The control word places M in bits 3:0, P in bits 17:16, the parent select in bits 24 and up (2 bits by default, bits 25:24), and the gate enable in bit 31. A write stores these fields, and a read on `rd_data` returns them in the cycle after the write. All other bits read as zero and ignore writes, so writing all ones reads back 0x8303000F.
- R2: While reset is asserted, and in the first cycle after reset, the control word reads zero, parent 0 is selected, and both `mod_ce` and `mod_clk` are low.
- R3: While enabled, `mod_ce` pulses once every D = (M+1)·2^P ticks of the selected parent, in the cycle after the tick that ends the period.
- R4: For D of 2 or more, `mod_clk` is high for floor(D/2) ticks of each period and low for the rest, so an odd D gives a high phase one tick shorter than the low phase. `mod_clk` rises only in the cycle in which `mod_ce` pulses.
- R5: With M=0 and P=0, `mod_ce` pulses after every tick of the selected parent.
- R6: When the gate bit is clear and the current period has ended, `mod_ce` and `mod_clk` stay low.
- R7: A write that changes M, P, the select or the gate while the output is running does not alter the current period. The new setting applies from the next period on.
- R8: Only ticks of the selected parent advance the divider. Ticks on the other parents have no effect on either output.
- R9: From the gated-off state, once the gate bit is set, the first tick of the selected parent starts a period with a `mod_ce` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Writes `wr_data` into the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read data; reserved bits are zero |
| parent_tick | input | 2**SEL_W | One tick per parent clock cycle, one bit per parent |
| mod_ce | output | 1 | One-cycle strobe at the start of each output period |
| mod_clk | output | 1 | Divided clock level |

## Verification
The hardest case to reach from the ports is a setting change that lands in the middle of a running period, while the selected parent ticks irregularly. In that case the old divide must finish on the old parent's ticks before the new select and ratio take over.

The stimulus covers this in several ways. It drives four parents at different cadences, one of them pseudo-random. It writes new settings at fixed cycle offsets that fall part-way through periods of 8, 20 and 128 ticks. It also clears the gate mid-period. A behavioural model predicts both outputs and the read data, and the bench compares them on every cycle.

// File: rtl/clkdiv_pkg.sv
// Package: field positions of the control word and the divide arithmetic
// shared by the register and the divider core.
// Assumes a 32-bit control word with fixed field offsets; the select width
// is chosen per instance.
package clkdiv_pkg;
    localparam int WORD_W  = 32;
    localparam int M_LSB   = 0;
    localparam int M_W     = 4;
    localparam int P_LSB   = 16;
    localparam int P_W     = 2;
    localparam int SEL_LSB = 24;
    localparam int EN_BIT  = 31;
    // width that holds the largest "divide minus one"
    localparam int DIV_W   = M_W + (1 << P_W) - 1;

    // Bits of the control word that hold state for a given select width.
    function automatic logic [WORD_W-1:0] field_mask(int sel_w);
        logic [WORD_W-1:0] mk;
        mk = '0;
        for (int i = 0; i < M_W; i++) mk[M_LSB+i] = 1'b1;
        for (int i = 0; i < P_W; i++) mk[P_LSB+i] = 1'b1;
        for (int i = 0; i < sel_w; i++) mk[SEL_LSB+i] = 1'b1;
        mk[EN_BIT] = 1'b1;
        return mk;
    endfunction

    // Last count value of a period: ((m+1) << p) - 1.
    function automatic logic [DIV_W-1:0] div_last(logic [M_W-1:0] m,
                                                   logic [P_W-1:0] p);
        logic [DIV_W:0] d;
        d = (DIV_W+1)'(m) + 1'b1;
        d = d << p;
        d = d - 1'b1;
        return d[DIV_W-1:0];
    endfunction

    // High-phase length in ticks: floor(D/2).
    function automatic logic [DIV_W-1:0] div_half(logic [DIV_W-1:0] last);
        logic [DIV_W:0] d;
        d = {1'b0, last} + 1'b1;
        d = d >> 1;
        return d[DIV_W-1:0];
    endfunction
endpackage

// File: rtl/clkdiv_ctrl_reg.sv
// Control word register: stores only the defined fields and splits them out.
// Assumes a single writer; reserved bits are never stored, so they read zero.
module clkdiv_ctrl_reg
    import clkdiv_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] word_o,
    output logic [M_W-1:0]    m_o,
    output logic [P_W-1:0]    p_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              en_o
);
    localparam logic [WORD_W-1:0] MASK = field_mask(SEL_W);

    logic [WORD_W-1:0] word_q;

    // Capture a write, dropping reserved bits; reset clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n)     word_q <= '0;
        else if (wr_en) word_q <= wr_data & MASK;
    end

    // Field split for the divider core.
    always_comb begin
        word_o = word_q;
        m_o    = word_q[M_LSB +: M_W];
        p_o    = word_q[P_LSB +: P_W];
        sel_o  = word_q[SEL_LSB +: SEL_W];
        en_o   = word_q[EN_BIT];
    end

    // R2: one cycle after a reset cycle the word is zero
    p_reset_clear_r2: assert property (@(posedge clk)
        !rst_n |=> (word_q == '0));
endmodule

// File: rtl/clkdiv_parent_sel.sv
// Parent selector: routes the tick of the chosen parent to the divider.
// Assumes exactly 2**SEL_W parents, so every select value is valid.
module clkdiv_parent_sel #(
    parameter int SEL_W = 2,
    localparam int NPAR = 1 << SEL_W
) (
    input  logic [NPAR-1:0]  ticks_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    // Pick one parent tick.
    always_comb tick_o = ticks_i[sel_i];
endmodule

// File: rtl/clkdiv_core.sv
// Divider core: counts selected parent ticks, emits the period strobe and
// the duty-cycle level, and adopts new settings only at period boundaries.
// Assumes the register fields are stable registered values.
module clkdiv_core
    import clkdiv_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [M_W-1:0]   m_i,
    input  logic [P_W-1:0]   p_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             en_i,
    input  logic             tick_i,
    output logic [SEL_W-1:0] sel_act_o,
    output logic             ce_o,
    output logic             lvl_o
);
    logic [M_W-1:0]   m_act;
    logic [P_W-1:0]   p_act;
    logic [SEL_W-1:0] sel_act;
    logic             en_act;
    logic [DIV_W-1:0] cnt;
    logic             ce_q, lvl_q;
    logic [DIV_W-1:0] last_act, last_new, half_act, half_new, cnt_inc;
    logic             wrap;

    // Period bounds for the running and the pending setting.
    always_comb begin
        last_act = div_last(m_act, p_act);
        last_new = div_last(m_i, p_i);
        half_act = div_half(last_act);
        half_new = div_half(last_new);
        cnt_inc  = cnt + 1'b1;
        wrap     = tick_i && (cnt == last_act);
    end

    // Count ticks, load the shadow setting at boundaries or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_act <= '0; p_act <= '0; sel_act <= '0; en_act <= 1'b0;
            cnt <= '0; ce_q <= 1'b0; lvl_q <= 1'b0;
        end else if (!en_act) begin
            m_act <= m_i; p_act <= p_i; sel_act <= sel_i; en_act <= en_i;
            cnt   <= last_new;
            ce_q  <= 1'b0;
            lvl_q <= 1'b0;
        end else if (wrap) begin
            m_act <= m_i; p_act <= p_i; sel_act <= sel_i; en_act <= en_i;
            cnt   <= '0;
            ce_q  <= en_i;
            lvl_q <= en_i && (half_new != '0);
        end else if (tick_i) begin
            cnt   <= cnt_inc;
            ce_q  <= 1'b0;
            lvl_q <= cnt_inc < half_act;
        end else begin
            ce_q  <= 1'b0;
        end
    end

    always_comb begin
        sel_act_o = sel_act;
        ce_o      = ce_q;
        lvl_o     = lvl_q;
    end

    // R8: a strobe is always caused by a selected tick one cycle earlier
    p_ce_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ce_q |-> $past(tick_i));
    // R3: the count never passes the end of the running period
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_act |-> (cnt <= last_act));
    // R7: the running setting is frozen until a period boundary
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_act && !wrap) |=> ($stable(m_act) && $stable(p_act) && $stable(sel_act)));
    // R4: the level only rises together with the period strobe
    p_rise_with_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_q) |-> ce_q);
    // R6: a gated-off divider keeps both outputs low
    p_gate_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_act |=> (!ce_q && !lvl_q));
endmodule

// File: rtl/clkdiv_gated_mux.sv
// Top: control word, parent selector and divider core.
// Assumes parent ticks are synchronous one-cycle pulses on clk.
module clkdiv_gated_mux
    import clkdiv_pkg::*;
#(
    parameter int SEL_W = 2,
    localparam int NPAR = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic [NPAR-1:0]   parent_tick,
    output logic              mod_ce,
    output logic              mod_clk
);
    logic [M_W-1:0]   f_m;
    logic [P_W-1:0]   f_p;
    logic [SEL_W-1:0] f_sel, sel_act;
    logic             f_en, sel_tick;

    clkdiv_ctrl_reg #(.SEL_W(SEL_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .word_o(rd_data), .m_o(f_m), .p_o(f_p), .sel_o(f_sel), .en_o(f_en)
    );

    clkdiv_parent_sel #(.SEL_W(SEL_W)) u_sel (
        .ticks_i(parent_tick), .sel_i(sel_act), .tick_o(sel_tick)
    );

    clkdiv_core #(.SEL_W(SEL_W)) u_core (
        .clk(clk), .rst_n(rst_n), .m_i(f_m), .p_i(f_p), .sel_i(f_sel),
        .en_i(f_en), .tick_i(sel_tick), .sel_act_o(sel_act),
        .ce_o(mod_ce), .lvl_o(mod_clk)
    );

    // R6: with the gate register clear and the core's last strobe gone, no new strobe
    p_no_ce_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!f_en && !mod_ce && !mod_clk && $past(!f_en)) |=> !mod_ce || $past(sel_tick));
endmodule

// File: tb/tb_clkdiv_gated_mux.sv
module tb_clkdiv_gated_mux;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MASK = 32'h8303_000F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  parent_tick = '0;
    logic        mod_ce, mod_clk;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit done = 0;
    logic [7:0] lfsr = 8'hA5;

    // behavioural reference state
    logic [31:0] r_word = '0;
    int a_m = 0, a_p = 0, a_sel = 0, a_en = 0, cnt = 0;
    bit e_ce = 0, e_lvl = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdiv_gated_mux #(.SEL_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .parent_tick(parent_tick),
        .mod_ce(mod_ce), .mod_clk(mod_clk)
    );

    function automatic int dval(int m, int p);
        return (m + 1) << p;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s cycle %0d: actual=%h expected=%h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic model(bit w, logic [31:0] d, logic [3:0] tk);
        int nm, np, ns, nen;
        if (!rst_n) begin
            r_word = '0; a_m = 0; a_p = 0; a_sel = 0; a_en = 0; cnt = 0;
            e_ce = 0; e_lvl = 0;
            return;
        end
        nm = int'(r_word[3:0]); np = int'(r_word[17:16]);
        ns = int'(r_word[25:24]); nen = int'(r_word[31]);
        if (a_en == 0) begin
            a_m = nm; a_p = np; a_sel = ns; a_en = nen;
            cnt = dval(nm, np) - 1; e_ce = 0; e_lvl = 0;
        end else if (tk[a_sel]) begin
            if (cnt == dval(a_m, a_p) - 1) begin
                a_m = nm; a_p = np; a_sel = ns; a_en = nen; cnt = 0;
                e_ce = (nen != 0);
                e_lvl = (nen != 0) && (dval(nm, np) / 2 > 0);
            end else begin
                cnt++;
                e_ce = 0;
                e_lvl = cnt < dval(a_m, a_p) / 2;
            end
        end else begin
            e_ce = 0;
        end
        if (w) r_word = d & MASK;
    endtask

    // one clock: drive, advance model at the edge, compare away from the edge
    task automatic step(bit w, logic [31:0] d, string tag);
        logic [3:0] tk;
        tk[0] = 1'b1;
        tk[1] = (cyc % 2) == 0;
        tk[2] = (cyc % 3) == 0;
        tk[3] = lfsr[0];
        wr_en = w; wr_data = d; parent_tick = tk;
        @(posedge clk);
        model(w, d, tk);
        @(negedge clk);
        check(tag, {31'b0, mod_ce}, {31'b0, e_ce}, "mod_ce");
        check(tag, {31'b0, mod_clk}, {31'b0, e_lvl}, "mod_clk");
        check(tag, rd_data, r_word, "rd_data");
        cyc++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) step(1'b0, '0, tag);
    endtask

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        run(3, "R2");
        rst_n = 1'b1;
        run(1, "R2");
        check("R2", rd_data, 32'h0, "reset word");
        check("R2", {30'b0, mod_ce, mod_clk}, 32'h0, "reset outputs");
        // R1: reserved bits dropped, defined fields kept
        step(1'b1, 32'hFFFF_FFFF, "R1");
        check("R1", rd_data, 32'h8303_000F, "all-ones readback");
        // R9: enable starts with a strobe on first selected tick (D=128, parent 3)
        run(300, "R9");
        // R6: clear the gate mid-period, outputs go quiet after the period
        step(1'b1, 32'h0000_0000, "R6");
        run(300, "R6");
        // R5: pass-through on parent 0
        step(1'b1, 32'h8000_0000, "R5");
        run(20, "R5");
        // R4: odd divide 3 on parent 0
        step(1'b1, 32'h8000_0002, "R4");
        run(30, "R4");
        // R3: M=3 P=1 on parent 1 -> 8 ticks
        step(1'b1, 32'h8101_0003, "R3");
        run(80, "R3");
        // R8: M=4 P=2 on parent 2 -> 20 ticks of a slow parent
        step(1'b1, 32'h8202_0004, "R8");
        run(90, "R8");
        // R7: change ratio and parent mid-period
        step(1'b1, 32'h8300_0005, "R7");
        run(200, "R7");
        step(1'b1, 32'h8001_0001, "R7");
        run(7, "R7");
        step(1'b1, 32'h8100_0006, "R7");
        run(120, "R7");
        // R6: gate off again, then check quiet outputs
        step(1'b1, 32'h0100_0006, "R6");
        run(60, "R6");
        check("R6", {30'b0, mod_ce, mod_clk}, 32'h0, "gated outputs");
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule